// File: doc/BRIEF.md
# Phase/Frequency Detector with Lock Control

This block compares a divided oscillator pulse against a reference pulse train, which in a radio synthesizer runs at 32 or 40 kHz, thirty-two times faster than the slower sample-and-hold comparison path. It produces up and down pulses for a charge pump. Each output is set by a rising edge of its own input and held until the other side's edge arrives. Both are then released together. The time between the two edges is measured in clock cycles. That measurement feeds a run-length counter, which declares lock once enough consecutive comparisons have fallen inside a narrow phase window.

A two-bit mode input sets how the detector output is enabled. In the automatic setting, the detector is switched off when lock is declared, so that the slower, cleaner path can hold the loop. It is switched back on by the first comparison that falls outside the window. The other two settings force the detector on or off. A four-bit charge-pump gain code passes straight through the block. The block raises a warning when the lowest gain code is in use while the loop is locked and the supply is low.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: After reset, `up_o`, `dn_o` and `locked_o` are 0. `det_en_o` is 1 in the automatic modes.
- R2: A rising edge on `ref_i` sets the internal up flag, and a rising edge on `fb_i` sets the internal down flag. When both flags are set at a clock edge, both are cleared at that edge. If the leading edge is seen L cycles before the trailing one, the leader's output is high for L+1 cycles and the follower's for 1 cycle.
- R3: A comparison counts as in phase when L is less than WIN_CYC (default 4). It counts as out of window when L is WIN_CYC or more.
- R4: `locked_o` rises at the end of the LOCK_N-th (default 16) consecutive in-phase comparison. After LOCK_N-1 such comparisons it is still 0.
- R5: An out-of-window comparison clears the run count and `locked_o` at the edge that ends the comparison.
- R6: `mode_i` encoding: bit 1 = 0 selects automatic mode, where `det_en_o` = NOT `locked_o`. 2'b10 forces `det_en_o` to 1, and 2'b11 forces it to 0.
- R7: While `det_en_o` is 0, `up_o` and `dn_o` stay 0. Comparisons and lock tracking continue.
- R8: `gain_o` equals `gain_i` in the same cycle.
- R9: `gain_warn_o` is 1 exactly when `gain_i` is 4'b0000, `locked_o` is 1 and `low_supply_i` is 1.
- R10: An input held high causes no further setting of its flag. Only a 0-to-1 transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference pulse |
| fb_i | input | 1 | Divided oscillator pulse |
| mode_i | input | 2 | Detector enable mode |
| gain_i | input | 4 | Charge-pump gain code |
| low_supply_i | input | 1 | Low supply indication |
| up_o | output | 1 | Charge-pump up request |
| dn_o | output | 1 | Charge-pump down request |
| det_en_o | output | 1 | Detector enabled |
| locked_o | output | 1 | Lock status (1 = locked) |
| gain_o | output | 4 | Gain code to charge pump |
| gain_warn_o | output | 1 | Lowest gain used while locked on low supply |

## Verification
A wrong pulse-width count or a lost edge shows up on `up_o` and `dn_o` as a pulse length that differs from L+1 within the same comparison. A run counter that is off by one, or that is not cleared, moves the rise of `locked_o`, and with it the fall of `det_en_o`, by one comparison. The bench therefore checks the lock state after every comparison of a full sweep of lead and lag values, so a fault of this kind is reported within one comparison of its first effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic [1:0] {
      MODE_AUTO_A    = 2'b00,
      MODE_AUTO_B    = 2'b01,
      MODE_FORCE_ON  = 2'b10,
      MODE_FORCE_OFF = 2'b11
   } det_mode_e;

   function automatic logic det_enable(input det_mode_e m, input logic lock);
      case (m)
         MODE_FORCE_ON:  det_enable = 1'b1;
         MODE_FORCE_OFF: det_enable = 1'b0;
         default:        det_enable = ~lock;
      endcase
   endfunction

endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
   parameter int WIN_CYC = 4,
   parameter int IN_SYNC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic fb_i,
   output logic up_q,
   output logic dn_q,
   output logic cmp_done,
   output logic cmp_inphase
);
   localparam int WW = $clog2(WIN_CYC + 1);
   localparam logic [WW-1:0] WSAT = WW'(WIN_CYC);

   logic ref_s, fb_s;
   logic ref_d, fb_d;
   logic [WW-1:0] wcnt;

   generate
      if (WIN_CYC < 1) begin : g_bad_win
         $error("WIN_CYC must be at least 1");
      end
      if (IN_SYNC < 0) begin : g_bad_sync
         $error("IN_SYNC must not be negative");
      end
      if (IN_SYNC == 0) begin : g_direct
         assign ref_s = ref_i;
         assign fb_s  = fb_i;
      end else begin : g_sync
         logic [IN_SYNC-1:0] rs, fs;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rs <= '0;
               fs <= '0;
            end else begin
               rs <= {rs[IN_SYNC-1:0], ref_i} >> 0;
               fs <= {fs[IN_SYNC-1:0], fb_i} >> 0;
            end
         end
         assign ref_s = rs[IN_SYNC-1];
         assign fb_s  = fs[IN_SYNC-1];
      end
   endgenerate

   logic rise_ref, rise_fb;
   assign rise_ref = ref_s & ~ref_d;
   assign rise_fb  = fb_s & ~fb_d;

   assign cmp_done    = up_q & dn_q;
   assign cmp_inphase = (wcnt < WSAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_d <= 1'b0;
         fb_d  <= 1'b0;
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
         wcnt  <= '0;
      end else begin
         ref_d <= ref_s;
         fb_d  <= fb_s;
         if (cmp_done) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
            wcnt <= '0;
         end else begin
            up_q <= up_q | rise_ref;
            dn_q <= dn_q | rise_fb;
            if ((up_q ^ dn_q) && (wcnt != WSAT))
               wcnt <= wcnt + 1'b1;
         end
      end
   end

   // R2: a completed comparison releases both flags on the next edge
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q) |=> (!up_q && !dn_q));

   // R2: a single set flag holds until the other side arrives
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q ^ dn_q) |=> (up_q || dn_q));

endmodule

// File: rtl/pfd_lock_count.sv
module pfd_lock_count #(
   parameter int LOCK_N = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_done,
   input  logic cmp_inphase,
   output logic in_lock
);
   localparam int LW = $clog2(LOCK_N + 1);
   localparam logic [LW-1:0] LSAT = LW'(LOCK_N);

   logic [LW-1:0] lcnt;
   logic [LW-1:0] lcnt_nx;

   generate
      if (LOCK_N < 2) begin : g_bad_lock
         $error("LOCK_N must be at least 2");
      end
   endgenerate

   always_comb begin
      lcnt_nx = lcnt;
      if (cmp_done) begin
         if (!cmp_inphase)        lcnt_nx = '0;
         else if (lcnt != LSAT)   lcnt_nx = lcnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt    <= '0;
         in_lock <= 1'b0;
      end else begin
         lcnt    <= lcnt_nx;
         in_lock <= (lcnt_nx == LSAT);
      end
   end

   // R5: an out-of-window comparison drops lock on the next edge
   assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && !cmp_inphase) |=> !in_lock);

   // R4: lock only ever rises at the end of an in-phase comparison
   assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_lock) |-> $past(cmp_done && cmp_inphase));

endmodule

// File: rtl/pfd_mode_ctl.sv
module pfd_mode_ctl
   import pfd_pkg::*;
#(
   parameter int GAIN_W = 4
) (
   input  logic [1:0]        mode_i,
   input  logic              in_lock,
   input  logic              up_q,
   input  logic              dn_q,
   input  logic [GAIN_W-1:0] gain_i,
   input  logic              low_supply_i,
   output logic              det_en,
   output logic              up_o,
   output logic              dn_o,
   output logic [GAIN_W-1:0] gain_o,
   output logic              gain_warn
);
   generate
      if (GAIN_W < 1) begin : g_bad_gain
         $error("GAIN_W must be at least 1");
      end
   endgenerate

   assign det_en    = det_enable(det_mode_e'(mode_i), in_lock);
   assign up_o      = up_q & det_en;
   assign dn_o      = dn_q & det_en;
   assign gain_o    = gain_i;
   assign gain_warn = (gain_i == '0) & in_lock & low_supply_i;

endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl #(
   parameter int WIN_CYC = 4,
   parameter int LOCK_N  = 16,
   parameter int GAIN_W  = 4,
   parameter int IN_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_i,
   input  logic              fb_i,
   input  logic [1:0]        mode_i,
   input  logic [GAIN_W-1:0] gain_i,
   input  logic              low_supply_i,
   output logic              up_o,
   output logic              dn_o,
   output logic              det_en_o,
   output logic              locked_o,
   output logic [GAIN_W-1:0] gain_o,
   output logic              gain_warn_o
);
   logic up_q, dn_q, cmp_done, cmp_inphase;

   pfd_edge_core #(.WIN_CYC(WIN_CYC), .IN_SYNC(IN_SYNC)) u_core (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i),
      .up_q(up_q), .dn_q(dn_q), .cmp_done(cmp_done), .cmp_inphase(cmp_inphase)
   );

   pfd_lock_count #(.LOCK_N(LOCK_N)) u_lock (
      .clk(clk), .rst_n(rst_n), .cmp_done(cmp_done),
      .cmp_inphase(cmp_inphase), .in_lock(locked_o)
   );

   pfd_mode_ctl #(.GAIN_W(GAIN_W)) u_mode (
      .mode_i(mode_i), .in_lock(locked_o), .up_q(up_q), .dn_q(dn_q),
      .gain_i(gain_i), .low_supply_i(low_supply_i), .det_en(det_en_o),
      .up_o(up_o), .dn_o(dn_o), .gain_o(gain_o), .gain_warn(gain_warn_o)
   );

   // R6/R7: in automatic mode, reaching lock silences the detector outputs
   assert_auto_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[1] && $rose(locked_o)) |-> (!up_o && !dn_o));

   // R9: the low-gain warning implies lock
   assert_warn_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gain_warn_o |-> locked_o);

endmodule

// File: tb/sim_pfd_lock_ctrl.sv
module sim_pfd_lock_ctrl;
   localparam int WIN = 4;
   localparam int LN  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_i = 1'b0, fb_i = 1'b0, low_supply_i = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic [3:0] gain_i = 4'd5;
   logic up_o, dn_o, det_en_o, locked_o, gain_warn_o;
   logic [3:0] gain_o;

   int vectors = 0, miscompares = 0;
   int lc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pfd_lock_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i), .mode_i(mode_i),
      .gain_i(gain_i), .low_supply_i(low_supply_i), .up_o(up_o), .dn_o(dn_o),
      .det_en_o(det_en_o), .locked_o(locked_o), .gain_o(gain_o),
      .gain_warn_o(gain_warn_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_lock();
      return lc >= LN;
   endfunction

   function automatic bit exp_det();
      if (mode_i[1]) return !mode_i[0];
      return !exp_lock();
   endfunction

   // lead > 0: ref leads by lead cycles; lead < 0: fb leads
   task automatic run_cmp(input int lead, input string req);
      int ra = (lead < 0) ? -lead : 0;
      int fa = (lead > 0) ? lead : 0;
      int mag = (lead < 0) ? -lead : lead;
      int nup = 0, ndn = 0;
      bit den = exp_det();
      int eup = den ? ((lead >= 0) ? lead + 1 : 1) : 0;
      int edn = den ? ((lead <= 0) ? -lead + 1 : 1) : 0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (up_o) nup++;
         if (dn_o) ndn++;
         ref_i = (i >= ra && i < ra + 6);   // held high: R10
         fb_i  = (i >= fa && i < fa + 6);
      end
      if (mag < WIN) begin
         if (lc < LN) lc++;
      end else lc = 0;
      chk({req, " R2/R10 up width"}, nup, eup);
      chk({req, " R2/R10 dn width"}, ndn, edn);
      chk({req, " R3/R4/R5 lock"}, locked_o, exp_lock());
      chk({req, " R6 det_en"}, det_en_o, exp_det());
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 up", up_o, 0);
      chk("R1 dn", dn_o, 0);
      chk("R1 lock", locked_o, 0);
      chk("R1 det_en", det_en_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 gain pass", gain_o, 5);

      // R2/R3/R5 sweep of lead and lag around the window
      for (int l = -7; l <= 7; l++) run_cmp(l, "sweep");

      // R4: LN-1 in-phase comparisons are not enough
      lc = 0;
      run_cmp(6, "R5 reset run");
      for (int k = 0; k < LN - 1; k++) run_cmp((k % 7) - 3, "R4 run");
      chk("R4 not yet locked", locked_o, 0);
      run_cmp(2, "R4 final");
      chk("R4 locked", locked_o, 1);
      chk("R6 auto off", det_en_o, 0);

      // R7: detector silent while locked, tracking continues
      run_cmp(-3, "R7 silent");
      run_cmp(3, "R7 silent");

      // R9 warning combinations
      gain_i = 4'd0; low_supply_i = 1'b1;
      @(negedge clk);
      chk("R9 warn on", gain_warn_o, 1);
      chk("R8 gain zero", gain_o, 0);
      low_supply_i = 1'b0;
      @(negedge clk);
      chk("R9 warn supply ok", gain_warn_o, 0);
      low_supply_i = 1'b1; gain_i = 4'd1;
      @(negedge clk);
      chk("R9 warn gain nonzero", gain_warn_o, 0);
      gain_i = 4'd0;

      // R5: one out-of-window comparison drops lock and re-enables
      run_cmp(-4, "R5 drop");
      chk("R9 warn after unlock", gain_warn_o, 0);

      // R6 forced on: lock reached but detector keeps driving
      mode_i = 2'b10;
      for (int k = 0; k < LN + 2; k++) run_cmp(k % 4, "R6 force on");
      chk("R6 forced on det_en", det_en_o, 1);

      // R6 forced off: no pulses even when unlocked
      mode_i = 2'b11;
      run_cmp(5, "R6 force off");
      run_cmp(-6, "R6 force off");
      chk("R6 forced off det_en", det_en_o, 0);

      // back to automatic, alternative encoding 2'b01
      mode_i = 2'b01;
      @(negedge clk);
      chk("R6 auto b", det_en_o, 1);
      for (int k = 0; k < LN; k++) run_cmp(-(k % 4), "R6 auto b run");
      chk("R6 auto b off", det_en_o, 0);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule